// File: doc/BRIEF.md
# Bridge-Steering PWM Output Stage

This block produces a pulse-width-modulated waveform with 10-bit duty resolution from an internal free-running timebase and routes it onto four drive outputs, A to D. Depending on a 2-bit configuration field, the waveform drives one pin alone, a complementary pair with dead-band insertion, or a full bridge in either direction. In a full bridge, one pin is modulated, one is held active and two are held inactive.

A 4-bit mode field turns PWM operation on and sets the polarity of the A/C pair and the B/D pair independently. A per-pin enable tells the surrounding pad logic which pins the block drives; pins it does not drive are left to general-purpose use. Duty and period are taken from their inputs only at a period boundary, so software may rewrite them at any time.

Top module: `pwm_bridge_steer`

## Requirements
- R1: The duty value is `{duty_hi, duty_lo}`, with `duty_lo` as the two least significant bits. A pin modulated with active-high polarity is high for exactly that many clocks in each period.
- R2: One period lasts 4*(period+1) clocks. The output is active while the 10-bit count is below the duty value, so a duty of zero gives a constantly inactive output and a duty at or above the period length gives a constantly active one.
- R3: PWM operation is on only when mode[3:2] = 11. Otherwise `pin_en` = 0000 and `pwm_out` = 0000, and the timebase is held at the start of a period.
- R4: With cfg = 00 (single), only A is modulated and `pin_en` = 0001.
- R5: With cfg = 01 (forward bridge), D is modulated, A is held active, B and C are held inactive, and `pin_en` = 1111.
- R6: With cfg = 10 (half bridge), A carries the waveform and B its complement. Each pin's transition to active is delayed by `dead` extra clocks, so the two are never active together. `pin_en` = 0011.
- R7: With cfg = 11 (reverse bridge), B is modulated, C is held active, A and D are held inactive, and `pin_en` = 1111.
- R8: mode[1] = 1 makes A and C active-low, and mode[0] = 1 makes B and D active-low. A cleared bit means active-high.
- R9: A pin whose `pin_en` bit is 0 has its `pwm_out` bit at 0.
- R10: A change of duty or period during a period takes effect at the start of the next period. The current period completes with the old values.
- R11: The `dead` value has no effect outside the half-bridge configuration.
- R12: While reset is held with a non-PWM mode, `pwm_out` and `pin_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 2 | Output steering configuration |
| mode | input | 4 | [3:2] = 11 enables PWM; [1] inverts A/C; [0] inverts B/D |
| duty_hi | input | PER_W | Upper duty bits |
| duty_lo | input | 2 | Lower two duty bits |
| period | input | PER_W | Period value; period length is 4*(period+1) clocks |
| dead | input | DB_W | Dead-band delay in clocks (half bridge only) |
| pwm_out | output | 4 | Drive levels, bit 0 = A through bit 3 = D |
| pin_en | output | 4 | Per-pin drive enable |

## Verification
On every cycle, the assertions check three things. In the half bridge, A and B are never both at their active level. Pins that are not enabled stay low. After a cycle in a stable full-bridge configuration, each bridge has its static pins at the required active and inactive levels. Only the bench scenarios can show the duty arithmetic, the period length, the dead-band loss in clocks per period, the effect of polarity on high-time counts, and the deferred update of duty at a period boundary. The bench measures these by counting output high-time over whole periods.

// File: rtl/pwm_bridge_steer.sv
module pwm_bridge_steer #(
  parameter int PER_W = 8,
  parameter int DB_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg,
  input  logic [3:0]       mode,
  input  logic [PER_W-1:0] duty_hi,
  input  logic [1:0]       duty_lo,
  input  logic [PER_W-1:0] period,
  input  logic [DB_W-1:0]  dead,
  output logic [3:0]       pwm_out,
  output logic [3:0]       pin_en
);
  localparam int CW = PER_W + 2;

  logic             pwm_on, half, wrap, pwm_raw;
  logic [CW-1:0]    cnt, duty_q;
  logic [PER_W-1:0] per_q;
  logic [3:0]       want, act, inv;
  logic [DB_W-1:0]  dly;

  assign pwm_on  = (mode[3:2] == 2'b11);
  assign half    = pwm_on && (cfg == 2'b10);
  assign wrap    = (cnt == {per_q, 2'b11});
  assign pwm_raw = (cnt < duty_q);
  assign dly     = half ? dead : '0;
  assign inv     = {mode[0], mode[1], mode[0], mode[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else if (!pwm_on || wrap) begin
      cnt    <= '0;
      duty_q <= {duty_hi, duty_lo};
      per_q  <= period;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    want   = 4'b0000;
    pin_en = 4'b0000;
    if (pwm_on) begin
      case (cfg)
        2'b00: begin want = {3'b000, pwm_raw};          pin_en = 4'b0001; end
        2'b01: begin want = {pwm_raw, 2'b00, 1'b1};     pin_en = 4'b1111; end
        2'b10: begin want = {2'b00, ~pwm_raw, pwm_raw}; pin_en = 4'b0011; end
        default: begin want = {2'b01, pwm_raw, 1'b0};   pin_en = 4'b1111; end
      endcase
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_pin
    logic [DB_W-1:0] dcnt;
    always_ff @(posedge clk) begin
      if (!rst_n || !want[i]) begin
        act[i] <= 1'b0;
        dcnt   <= '0;
      end else if (dcnt >= dly) begin
        act[i] <= 1'b1;
      end else begin
        dcnt   <= dcnt + 1'b1;
      end
    end
  end

  assign pwm_out = pin_en & (act ^ inv);
endmodule

// File: rtl/pwm_bridge_steer_chk.sv
module pwm_bridge_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg,
  input logic [3:0] mode,
  input logic [3:0] pwm_out,
  input logic [3:0] pin_en
);
  logic       up_q, on;
  logic [3:0] lvl;

  assign on  = (mode[3:2] == 2'b11);
  assign lvl = pwm_out ^ {mode[0], mode[1], mode[0], mode[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  // R6
  half_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && on && cfg == 2'b10) |-> !(lvl[0] && lvl[1]));

  // R9
  idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~pin_en) == 4'b0000);

  // R5
  fwd_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && on && cfg == 2'b01 && $past(on) && $past(cfg) == 2'b01)
      |-> (lvl[0] && !lvl[1] && !lvl[2]));

  // R7
  rev_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && on && cfg == 2'b11 && $past(on) && $past(cfg) == 2'b11)
      |-> (lvl[2] && !lvl[0] && !lvl[3]));
endmodule

bind pwm_bridge_steer pwm_bridge_steer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .mode(mode),
  .pwm_out(pwm_out), .pin_en(pin_en)
);

// File: tb/pwm_bridge_steer_tb_top.sv
`timescale 1ns/1ps
module pwm_bridge_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg = 2'b00;
  logic [3:0] mode = 4'b0000;
  logic [7:0] duty_hi = 8'd0;
  logic [1:0] duty_lo = 2'b00;
  logic [7:0] period = 8'd7;
  logic [5:0] dead = 6'd0;
  logic [3:0] pwm_out, pin_en;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwm_bridge_steer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .mode(mode),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .period(period), .dead(dead),
    .pwm_out(pwm_out), .pin_en(pin_en)
  );

  typedef struct packed {
    logic [1:0] cfg;
    logic [3:0] mode;
    logic [7:0] dh;
    logic [1:0] dl;
    logic [7:0] per;
    logic [5:0] dead;
    logic [3:0] en;
    logic [7:0] ca, cb, cc, cd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 4'b1100, 8'd3,   2'd2, 8'd7, 6'd0, 4'b0001, 8'd14, 8'd0,  8'd0,  8'd0,  4'd4},
    '{2'b00, 4'b1111, 8'd3,   2'd2, 8'd7, 6'd0, 4'b0001, 8'd18, 8'd0,  8'd0,  8'd0,  4'd8},
    '{2'b01, 4'b1100, 8'd3,   2'd2, 8'd7, 6'd0, 4'b1111, 8'd32, 8'd0,  8'd0,  8'd14, 4'd5},
    '{2'b01, 4'b1101, 8'd3,   2'd2, 8'd7, 6'd0, 4'b1111, 8'd32, 8'd32, 8'd0,  8'd18, 4'd8},
    '{2'b11, 4'b1100, 8'd3,   2'd2, 8'd7, 6'd0, 4'b1111, 8'd0,  8'd14, 8'd32, 8'd0,  4'd7},
    '{2'b11, 4'b1110, 8'd3,   2'd2, 8'd7, 6'd0, 4'b1111, 8'd32, 8'd14, 8'd0,  8'd0,  4'd8},
    '{2'b10, 4'b1100, 8'd3,   2'd2, 8'd7, 6'd0, 4'b0011, 8'd14, 8'd18, 8'd0,  8'd0,  4'd6},
    '{2'b10, 4'b1100, 8'd3,   2'd2, 8'd7, 6'd3, 4'b0011, 8'd11, 8'd15, 8'd0,  8'd0,  4'd6},
    '{2'b10, 4'b1111, 8'd3,   2'd2, 8'd7, 6'd3, 4'b0011, 8'd21, 8'd17, 8'd0,  8'd0,  4'd8},
    '{2'b00, 4'b1100, 8'd0,   2'd0, 8'd7, 6'd0, 4'b0001, 8'd0,  8'd0,  8'd0,  8'd0,  4'd2},
    '{2'b00, 4'b1100, 8'd200, 2'd0, 8'd7, 6'd0, 4'b0001, 8'd32, 8'd0,  8'd0,  8'd0,  4'd2},
    '{2'b01, 4'b0010, 8'd3,   2'd2, 8'd7, 6'd0, 4'b0000, 8'd0,  8'd0,  8'd0,  8'd0,  4'd3},
    '{2'b00, 4'b1100, 8'd3,   2'd0, 8'd7, 6'd0, 4'b0001, 8'd12, 8'd0,  8'd0,  8'd0,  4'd1},
    '{2'b00, 4'b1100, 8'd3,   2'd2, 8'd7, 6'd5, 4'b0001, 8'd14, 8'd0,  8'd0,  8'd0,  4'd11},
    '{2'b00, 4'b1100, 8'd5,   2'd0, 8'd3, 6'd0, 4'b0001, 8'd16, 8'd0,  8'd0,  8'd0,  4'd2},
    '{2'b00, 4'b1100, 8'd2,   2'd1, 8'd3, 6'd0, 4'b0001, 8'd9,  8'd0,  8'd0,  8'd0,  4'd1}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    int hc [4];
    n = 4 * (int'(v.per) + 1);
    @(negedge clk);
    mode = 4'b0000;
    cfg = v.cfg; duty_hi = v.dh; duty_lo = v.dl; period = v.per; dead = v.dead;
    repeat (2) @(negedge clk);
    mode = v.mode;
    repeat (2 * n) @(negedge clk);
    check(tag(v.req), int'(pin_en), int'(v.en), "pin_en");
    for (int p = 0; p < 4; p++) hc[p] = 0;
    for (int k = 0; k < n; k++) begin
      for (int p = 0; p < 4; p++) if (pwm_out[p]) hc[p]++;
      @(negedge clk);
    end
    check(tag(v.req), hc[0], int'(v.ca), "A high clocks");
    check(tag(v.req), hc[1], int'(v.cb), "B high clocks");
    check(tag(v.req), hc[2], int'(v.cc), "C high clocks");
    check(tag(v.req), hc[3], int'(v.cd), "D high clocks");
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int cnt;
    repeat (3) @(negedge clk);
    // R12: outputs quiet under reset
    check("R12", int'(pwm_out), 0, "pwm_out in reset");
    check("R12", int'(pin_en), 0, "pin_en in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: duty rewrite mid-period is deferred to the next period
    @(negedge clk);
    mode = 4'b0000; cfg = 2'b00; duty_hi = 8'd3; duty_lo = 2'd2; period = 8'd7; dead = 6'd0;
    repeat (2) @(negedge clk);
    mode = 4'b1100;
    repeat (40) @(negedge clk);
    while (pwm_out[0]) @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    duty_hi = 8'd1; duty_lo = 2'd0;
    cnt = 0;
    for (int k = 0; k < 32; k++) begin
      if (pwm_out[0]) cnt++;
      @(negedge clk);
    end
    check("R10", cnt, 14, "old duty kept for current period");
    cnt = 0;
    for (int k = 0; k < 32; k++) begin
      if (pwm_out[0]) cnt++;
      @(negedge clk);
    end
    check("R10", cnt, 4, "new duty in next period");

    // R9: disabled pins low under inverted polarity in single mode
    mode = 4'b1111;
    repeat (3) @(negedge clk);
    check("R9", int'(pwm_out[3:1]), 0, "disabled pins");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule